// File: doc/BRIEF.md
# Parallel Step Sequence Controller

This block runs a fixed chart of seven steps that move on transition conditions sampled each clock. A start step forks into two branches of two steps each. The branches meet at a merge step, which the chart enters only when both branch ends are active and the join condition is true. From the merge step there are two exits. The left exit returns to the start step and takes priority. The right exit goes to a side step, which later returns to the start step.

Every active step is a flag register. On each clock, all transitions are evaluated against the step flags as they stood before that edge. Four action outputs follow the step flags:

- a plain action that is on while its step is active;
- a set/reset latch;
- a delayed action that uses an on-delay counter;
- a time-limited action that uses a second on-delay counter.

Both counter presets are inputs, counted in clock cycles.

Top module: `sfc_step_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sets `step_o` to 7'h01, where bit0 is the start step, bit1/bit2 are branch A first/last, bit3/bit4 are branch B first/last, bit5 is the merge step and bit6 is the side step. Reset also clears the latch and reloads both counters, so all four action outputs are low after reset.
- R2: If the start step is active and `cond_i[0]` (fork) is high, then after the edge both first branch steps are active and the start step is clear.
- R3: A step moves forward by at most one place per clock. If a condition is held high, a step entered on one edge stays active for at least that cycle, even when its outgoing condition (`cond_i[1]` A-advance, `cond_i[2]` B-advance) is already high.
- R4: The merge step is entered only on an edge where both branch-last steps are active and `cond_i[3]` (join) is high. That edge clears both branch-last steps. With only one branch ready, join has no effect.
- R5: If the merge step is active and both `cond_i[4]` (left exit) and `cond_i[5]` (right exit) are high, the start step is entered and the side step is not. `cond_i[6]` returns the side step to the start step.
- R6: `act_run_o` is high in exactly the cycles in which branch A's first step is active.
- R7: `act_hold_o` goes high on the edge after a cycle in which branch A's last step is active. It goes low on the edge after a cycle in which the side step is active. Clearing wins if both apply.
- R8: `act_delay_o` is high once branch B's first step has been active through `dly_preset_i` edges since entry; with a preset of 0 it is high from entry. It drops in the cycle the step ends. If the step ends before the count runs out, the output never rises.
- R9: `act_limit_o` is high in the first `lim_preset_i` cycles of the merge step, counting the entry cycle. It is low after that and low once the step ends. A preset of 0 keeps it low.
- R10: A condition whose source step is inactive has no effect on `step_o`. This includes fork while the start step is inactive, and advance, join or exit conditions before their steps are reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 7 | Transition conditions, bit map as in R2 to R5 |
| dly_preset_i | input | CNT_W | Delay preset in cycles for the delayed action |
| lim_preset_i | input | CNT_W | Limit preset in cycles for the limited action |
| step_o | output | 7 | Active step flags, bit map as in R1 |
| act_run_o | output | 1 | Plain action of branch A first step |
| act_hold_o | output | 1 | Latched action (set by A last, cleared by side) |
| act_delay_o | output | 1 | Delayed action of branch B first step |
| act_limit_o | output | 1 | Time-limited action of the merge step |

## Verification
The hardest situation to reach is a join attempt while only one branch has finished. That needs the two branches advanced on different edges while the join condition is held high the whole time. The stimulus advances branch A first and keeps join high across the cycle in which branch B advances. This shows that join cannot fire in the same edge that makes branch B ready. A second pass leaves branch B early to abort the delay count. It also runs the merge step with a zero limit preset and then takes the side route, which clears the latch.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int NSTEP = 7;
  localparam int NCOND = 7;

  // step flag positions
  localparam int ST_INIT  = 0;
  localparam int ST_A0    = 1;
  localparam int ST_A1    = 2;
  localparam int ST_B0    = 3;
  localparam int ST_B1    = 4;
  localparam int ST_MERGE = 5;
  localparam int ST_SIDE  = 6;

  // condition / transition positions
  localparam int TR_FORK  = 0;
  localparam int TR_A     = 1;
  localparam int TR_B     = 2;
  localparam int TR_JOIN  = 3;
  localparam int TR_LEFT  = 4;
  localparam int TR_RIGHT = 5;
  localparam int TR_BACK  = 6;

  localparam logic [NSTEP-1:0] INIT_MASK = NSTEP'(1) << ST_INIT;

  // timer slots inside the action unit
  localparam int NTMR    = 2;
  localparam int TM_DLY  = 0;
  localparam int TM_LIM  = 1;
endpackage

// File: rtl/sfc_trans_net.sv
module sfc_trans_net
  import sfc_pkg::*;
(
  input  logic [NSTEP-1:0] st,
  input  logic [NCOND-1:0] cond,
  output logic [NSTEP-1:0] enter,
  output logic [NSTEP-1:0] leave
);
  logic [NCOND-1:0] fire;

  // every transition sees only the pre-edge step flags
  always_comb begin
    fire           = '0;
    fire[TR_FORK]  = st[ST_INIT] & cond[TR_FORK];
    fire[TR_A]     = st[ST_A0] & cond[TR_A];
    fire[TR_B]     = st[ST_B0] & cond[TR_B];
    fire[TR_JOIN]  = st[ST_A1] & st[ST_B1] & cond[TR_JOIN];
    fire[TR_LEFT]  = st[ST_MERGE] & cond[TR_LEFT];
    // the right exit yields to the left exit
    fire[TR_RIGHT] = st[ST_MERGE] & cond[TR_RIGHT] & ~cond[TR_LEFT];
    fire[TR_BACK]  = st[ST_SIDE] & cond[TR_BACK];
  end

  always_comb begin
    enter           = '0;
    leave           = '0;
    enter[ST_INIT]  = fire[TR_LEFT] | fire[TR_BACK];
    leave[ST_INIT]  = fire[TR_FORK];
    enter[ST_A0]    = fire[TR_FORK];
    leave[ST_A0]    = fire[TR_A];
    enter[ST_A1]    = fire[TR_A];
    leave[ST_A1]    = fire[TR_JOIN];
    enter[ST_B0]    = fire[TR_FORK];
    leave[ST_B0]    = fire[TR_B];
    enter[ST_B1]    = fire[TR_B];
    leave[ST_B1]    = fire[TR_JOIN];
    enter[ST_MERGE] = fire[TR_JOIN];
    leave[ST_MERGE] = fire[TR_LEFT] | fire[TR_RIGHT];
    enter[ST_SIDE]  = fire[TR_RIGHT];
    leave[ST_SIDE]  = fire[TR_BACK];
  end
endmodule

// File: rtl/sfc_step_reg.sv
module sfc_step_reg
  import sfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSTEP-1:0] enter,
  input  logic [NSTEP-1:0] leave,
  output logic [NSTEP-1:0] st
);
  for (genvar i = 0; i < NSTEP; i++) begin : g_step
    always_ff @(posedge clk) begin
      if (rst) st[i] <= INIT_MASK[i];
      else     st[i] <= (st[i] & ~leave[i]) | enter[i];
    end
  end
endmodule

// File: rtl/sfc_ondelay.sv
module sfc_ondelay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] preset,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  // reload while idle, count down while running, hold at zero
  always_ff @(posedge clk) begin
    if (rst || !run)       cnt <= preset;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == '0);
endmodule

// File: rtl/sfc_action_unit.sv
module sfc_action_unit
  import sfc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSTEP-1:0] st,
  input  logic [CNT_W-1:0] dly_preset,
  input  logic [CNT_W-1:0] lim_preset,
  output logic             act_run,
  output logic             act_hold,
  output logic             act_delay,
  output logic             act_limit
);
  logic [NTMR-1:0]  tm_run;
  logic [NTMR-1:0]  tm_done;
  logic [CNT_W-1:0] tm_pre [NTMR];

  assign tm_run[TM_DLY] = st[ST_B0];
  assign tm_pre[TM_DLY] = dly_preset;
  assign tm_run[TM_LIM] = st[ST_MERGE];
  assign tm_pre[TM_LIM] = lim_preset;

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    sfc_ondelay #(.CNT_W(CNT_W)) tmr_i (
      .clk    (clk),
      .rst    (rst),
      .run    (tm_run[g]),
      .preset (tm_pre[g]),
      .done   (tm_done[g])
    );
  end

  // latched action: clear dominates set
  always_ff @(posedge clk) begin
    if (rst || st[ST_SIDE]) act_hold <= 1'b0;
    else if (st[ST_A1])     act_hold <= 1'b1;
  end

  assign act_run   = st[ST_A0];
  assign act_delay = tm_done[TM_DLY];
  assign act_limit = tm_run[TM_LIM] & ~tm_done[TM_LIM];
endmodule

// File: rtl/sfc_step_ctrl.sv
module sfc_step_ctrl
  import sfc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCOND-1:0] cond_i,
  input  logic [CNT_W-1:0] dly_preset_i,
  input  logic [CNT_W-1:0] lim_preset_i,
  output logic [NSTEP-1:0] step_o,
  output logic             act_run_o,
  output logic             act_hold_o,
  output logic             act_delay_o,
  output logic             act_limit_o
);
  logic [NSTEP-1:0] st;
  logic [NSTEP-1:0] enter;
  logic [NSTEP-1:0] leave;

  sfc_trans_net net_i (
    .st    (st),
    .cond  (cond_i),
    .enter (enter),
    .leave (leave)
  );

  sfc_step_reg reg_i (
    .clk   (clk),
    .rst   (rst),
    .enter (enter),
    .leave (leave),
    .st    (st)
  );

  sfc_action_unit #(.CNT_W(CNT_W)) act_i (
    .clk        (clk),
    .rst        (rst),
    .st         (st),
    .dly_preset (dly_preset_i),
    .lim_preset (lim_preset_i),
    .act_run    (act_run_o),
    .act_hold   (act_hold_o),
    .act_delay  (act_delay_o),
    .act_limit  (act_limit_o)
  );

  assign step_o = st;
endmodule

// File: rtl/sfc_step_ctrl_chk.sv
module sfc_step_ctrl_chk
  import sfc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [NCOND-1:0] cond,
  input logic [NSTEP-1:0] st,
  input logic             act_hold,
  input logic             act_delay,
  input logic             act_limit
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (st == INIT_MASK) && !act_hold);

  // R2
  fork_chk: assert property (@(posedge clk) disable iff (rst)
    (st[ST_INIT] && cond[TR_FORK]) |=> (st[ST_A0] && st[ST_B0] && !st[ST_INIT]));

  // R3
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st[ST_A1]) |-> $past(st[ST_A0]));

  // R4
  join_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st[ST_MERGE]) |-> (!st[ST_A1] && !st[ST_B1]));

  // R5
  left_first_chk: assert property (@(posedge clk) disable iff (rst)
    (st[ST_MERGE] && cond[TR_LEFT]) |=> (st[ST_INIT] && !st[ST_SIDE]));

  // R7
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    st[ST_SIDE] |=> !act_hold);

  // R8
  delay_in_step_chk: assert property (@(posedge clk) disable iff (rst)
    act_delay |-> st[ST_B0]);

  // R9
  limit_in_step_chk: assert property (@(posedge clk) disable iff (rst)
    act_limit |-> st[ST_MERGE]);
endmodule

bind sfc_step_ctrl sfc_step_ctrl_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .cond      (cond_i),
  .st        (step_o),
  .act_hold  (act_hold_o),
  .act_delay (act_delay_o),
  .act_limit (act_limit_o)
);

// File: tb/sfc_step_ctrl_tb_top.sv
module sfc_step_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  typedef struct {
    logic [6:0] st;
    logic [3:0] act;
    string      req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [6:0]    cond = '0;
  logic [CW-1:0] dly = CW'(3);
  logic [CW-1:0] lim = CW'(2);
  logic [6:0]    step_o;
  logic          act_run_o, act_hold_o, act_delay_o, act_limit_o;

  exp_t sb_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfc_step_ctrl #(.CNT_W(CW)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .cond_i       (cond),
    .dly_preset_i (dly),
    .lim_preset_i (lim),
    .step_o       (step_o),
    .act_run_o    (act_run_o),
    .act_hold_o   (act_hold_o),
    .act_delay_o  (act_delay_o),
    .act_limit_o  (act_limit_o)
  );

  // act order: {run, hold, delay, limit}
  task automatic cyc(input logic [6:0] c, input logic [6:0] es,
                     input logic [3:0] ea, input string rq);
    cond = c;
    @(posedge clk);
    #1;
    sb_q.push_back('{st: es, act: ea, req: rq});
  endtask

  // monitor
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t it;
      logic [3:0] a;
      it = sb_q.pop_front();
      a  = {act_run_o, act_hold_o, act_delay_o, act_limit_o};
      n_cmp++;
      if (step_o !== it.st || a !== it.act) begin
        n_bad++;
        $display("FAIL %s: step=%h act=%b expected step=%h act=%b",
                 it.req, step_o, a, it.st, it.act);
      end
    end
  end

  initial begin
    // R1 reset state
    rst = 1'b1;
    cyc(7'h00, 7'h01, 4'b0000, "R1");
    cyc(7'h00, 7'h01, 4'b0000, "R1");
    rst = 1'b0;
    // R10 all conditions except fork: no effect
    cyc(7'b1111110, 7'h01, 4'b0000, "R10");
    // R2 fork, R3 held advance conditions do not cascade
    cyc(7'b0000111, 7'h0A, 4'b1000, "R2");
    // R6 run drops when A0 leaves
    cyc(7'b0000010, 7'h0C, 4'b0000, "R6");
    // R4 join with only branch A ready: ignored; R7 hold set
    cyc(7'b0001000, 7'h0C, 4'b0100, "R4");
    // R8 delay rises after 3 edges in B0
    cyc(7'b0000000, 7'h0C, 4'b0110, "R8");
    // R3 join held while B advances: no same-edge join; R8 drop
    cyc(7'b0001100, 7'h14, 4'b0100, "R3");
    // R4 join fires; R9 limit on at entry
    cyc(7'b0001000, 7'h20, 4'b0101, "R4");
    cyc(7'b0000000, 7'h20, 4'b0101, "R9");
    cyc(7'b0000000, 7'h20, 4'b0100, "R9");
    // R5 both exits: left wins
    cyc(7'b0110000, 7'h01, 4'b0100, "R5");
    // second pass
    cyc(7'b0000001, 7'h0A, 4'b1100, "R2");
    // R8 B0 left early: delay never rises
    cyc(7'b0000100, 7'h12, 4'b1100, "R8");
    lim = '0;
    cyc(7'b0000010, 7'h14, 4'b0100, "R6");
    // R9 zero limit preset: never high
    cyc(7'b0001000, 7'h20, 4'b0100, "R9");
    cyc(7'b0100000, 7'h40, 4'b0100, "R5");
    // R7 side clears hold; R10 fork ignored when start inactive
    cyc(7'b1000001, 7'h01, 4'b0000, "R7");
    cyc(7'b0000000, 7'h01, 4'b0000, "R10");
    cyc(7'b0000001, 7'h0A, 4'b1000, "R2");
    // R1 mid-sequence reset
    rst = 1'b1;
    cyc(7'b0000010, 7'h01, 4'b0000, "R1");
    rst = 1'b0;
    dly = '0;
    // R8 zero delay preset: high from entry
    cyc(7'b0000001, 7'h0A, 4'b1010, "R8");
    cyc(7'b0000000, 7'h0A, 4'b1010, "R8");
    @(negedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule